// File: doc/BRIEF.md
# Dual Serial Gamepad Reader

This block connects a processor bus to two eight-button gamepads. Each pad holds its buttons in a parallel-load shift register, and all pads share a latch line and a clock line. A write of any value to the strobe address starts one capture for both pads. The block raises the latch line and then gives eight clock pulses. It samples each pad's data line once per bit and collects the bits in a capture register for each pad. When the eighth bit is in, the capture registers replace the two shadow bytes.

Software reads the pads one button at a time. A read of the pad-one address returns pad one's current button in bit 0, and a read of the next address does the same for pad two. Each read moves that pad's shadow byte on by one button. The data is active low: a pressed button reads as 0. Once eight buttons have been read, that pad returns 1 until the next capture completes. Pin timing is set by one parameter, counted in system clocks.

Top module: `pad_pair_reader`

## Requirements
- R1: After reset, the latch output is low, the pad clock output is high, and a read of either pad address returns 8'h01.
- R2: A write to BASE_ADDR (default 0x4016), whatever the data, raises the latch for HALF_CYCLES clocks. Eight pad-clock pulses follow, and each pulse is low for HALF_CYCLES clocks and high for HALF_CYCLES clocks.
- R3: The pad clock is high whenever it is not pulsing and whenever the latch is high.
- R4: A read of BASE_ADDR returns pad one's current button and a read of BASE_ADDR+1 returns pad two's, in bit 0, with bits 7:1 equal to 0. A pressed button reads as 0 and a released one as 1.
- R5: After a capture, successive reads of one pad return its buttons in this order: A, B, Select, Start, Up, Down, Left, Right. Bit 0 of the bench's button vector is A and bit 7 is Right.
- R6: After the eighth read of a pad, any further read of that pad returns 1 until the next capture completes.
- R7: A read made while a capture is running returns the previous shadow byte and advances it. The new buttons take effect only once all eight bits have been taken, and reading then starts again at A.
- R8: A strobe write made while a capture is running is ignored. The running capture still gives exactly eight pulses and only one latch pulse.
- R9: A write to BASE_ADDR+1 starts no capture. A read of an address other than the two pad addresses returns 0 and advances neither pad.
- R10: Reading one pad does not advance the other pad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Bus address |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| pad_latch | output | 1 | Parallel-load line shared by both pads |
| pad_clk | output | 1 | Shift clock shared by both pads, idles high |
| pad_data | input | 2 | Serial data from the pads; bit 0 is pad one |

## Verification
Random button vectors for both pads are mixed with the directed patterns all pressed, none pressed, only A and only Right. Single-button patterns expose a reversed or shifted bit order, and the all and none patterns expose inverted polarity. Random read runs of 0 to 11 accesses, interleaved between the pads, separate the per-pad read pointers and exercise the exhausted state after eight reads. Directed cases cover a read during a capture, a second strobe during a capture, a write to the second pad address and a read of an unrelated address. In each case the effect is seen on bus_rdata or on the pad pins.

// File: rtl/pad_pkg.sv
package pad_pkg;
  localparam int unsigned PAD_BUTTONS = 8;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_LATCH = 2'd1,
    SEQ_HIGH  = 2'd2,
    SEQ_LOW   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/pad_seq.sv
module pad_seq
  import pad_pkg::*;
#(
  parameter int unsigned HALF_CYCLES = 1500,
  parameter int unsigned BITS        = PAD_BUTTONS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic sample,
  output logic done,
  output logic pad_latch,
  output logic pad_clk
);
  localparam int unsigned CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam int unsigned BW = (BITS > 1) ? $clog2(BITS) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF_CYCLES - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(BITS - 1);

  seq_state_e    state_q, state_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [BW-1:0] bit_q, bit_n;
  logic          latch_q, clk_q;
  logic          tick;

  assign tick = (cnt_q == CNT_LAST);
  assign busy = (state_q != SEQ_IDLE);

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    bit_n   = bit_q;
    sample  = 1'b0;
    done    = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (start) begin
          state_n = SEQ_LATCH;
          cnt_n   = '0;
        end
      end
      SEQ_LATCH: begin
        if (tick) begin
          state_n = SEQ_HIGH;
          cnt_n   = '0;
        end else begin
          cnt_n = cnt_q + CW'(1);
        end
      end
      SEQ_HIGH: begin
        if (tick) begin
          sample  = 1'b1;
          state_n = SEQ_LOW;
          cnt_n   = '0;
        end else begin
          cnt_n = cnt_q + CW'(1);
        end
      end
      SEQ_LOW: begin
        if (tick) begin
          cnt_n = '0;
          if (bit_q == BIT_LAST) begin
            done    = 1'b1;
            state_n = SEQ_IDLE;
            bit_n   = '0;
          end else begin
            bit_n   = bit_q + BW'(1);
            state_n = SEQ_HIGH;
          end
        end else begin
          cnt_n = cnt_q + CW'(1);
        end
      end
      default: state_n = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      latch_q <= 1'b0;
      clk_q   <= 1'b1;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      bit_q   <= bit_n;
      latch_q <= (state_n == SEQ_LATCH);
      clk_q   <= (state_n != SEQ_LOW);
    end
  end

  assign pad_latch = latch_q;
  assign pad_clk   = clk_q;

  AST_LATCH_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    pad_latch |-> pad_clk); // R3
  AST_START_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> pad_latch); // R2
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> !$rose(pad_latch)); // R8
  AST_SAMPLE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sample |-> (pad_clk && !pad_latch)); // R2
endmodule

// File: rtl/pad_shadow.sv
module pad_shadow
  import pad_pkg::*;
#(
  parameter int unsigned BITS = PAD_BUTTONS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pad_din,
  input  logic sample,
  input  logic load,
  input  logic rd,
  output logic rd_bit
);
  logic [1:0]      sync_q;
  logic [BITS-1:0] cap_q, cap_n;
  logic [BITS-1:0] shadow_q, shadow_n;

  always_comb begin
    cap_n    = cap_q;
    shadow_n = shadow_q;
    if (sample) cap_n = {sync_q[1], cap_q[BITS-1:1]};
    if (load) begin
      shadow_n = cap_n;
    end else if (rd) begin
      shadow_n = {1'b1, shadow_q[BITS-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= 2'b11;
      cap_q    <= '1;
      shadow_q <= '1;
    end else begin
      sync_q <= {sync_q[0], pad_din};
      if (sample) cap_q <= cap_n;
      if (load || rd) shadow_q <= shadow_n;
    end
  end

  assign rd_bit = shadow_q[0];

  AST_HOLD_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd && !load) |=> $stable(shadow_q)); // R7
  AST_EXHAUSTED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !load && (&shadow_q)) |=> (&shadow_q)); // R6
endmodule

// File: rtl/pad_pair_reader.sv
module pad_pair_reader
  import pad_pkg::*;
#(
  parameter int unsigned       HALF_CYCLES = 1500,
  parameter int unsigned       ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR   = 16'h4016
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  output logic              pad_latch,
  output logic              pad_clk,
  input  logic [1:0]        pad_data
);
  localparam int unsigned NPADS = 2;

  logic [1:0]       rst_pipe_q;
  logic             rst_n_i;
  logic             start;
  logic             busy;
  logic             sample;
  logic             done;
  logic [NPADS-1:0] rd_sel;
  logic [NPADS-1:0] rd_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_i = rst_pipe_q[1];

  assign start = bus_wr && (bus_addr == BASE_ADDR);

  pad_seq #(
    .HALF_CYCLES(HALF_CYCLES),
    .BITS       (PAD_BUTTONS)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .start    (start),
    .busy     (busy),
    .sample   (sample),
    .done     (done),
    .pad_latch(pad_latch),
    .pad_clk  (pad_clk)
  );

  for (genvar g = 0; g < NPADS; g++) begin : g_pad
    localparam logic [ADDR_W-1:0] PAD_ADDR = BASE_ADDR + ADDR_W'(g);
    assign rd_sel[g] = bus_rd && (bus_addr == PAD_ADDR);

    pad_shadow #(
      .BITS(PAD_BUTTONS)
    ) u_shadow (
      .clk    (clk),
      .rst_n  (rst_n_i),
      .pad_din(pad_data[g]),
      .sample (sample),
      .load   (done),
      .rd     (rd_sel[g]),
      .rd_bit (rd_bit[g])
    );
  end

  assign bus_rdata = {7'b0, |(rd_sel & rd_bit)};

  AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n_i)
    $onehot0(rd_sel)); // R10
  AST_DONE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n_i)
    done |-> busy); // R7
endmodule

// File: tb/pad_pair_reader_bench.sv
module pad_pair_reader_bench;
  localparam int unsigned H     = 4;
  localparam logic [15:0] BASE  = 16'h4016;
  localparam int          SPAN  = 17 * H + 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic        pad_latch, pad_clk;
  logic [1:0]  pad_data;

  logic [7:0] press [2];
  logic [7:0] sreg  [2];
  logic [7:0] cur   [2];
  int         idx   [2];
  int checks = 0;
  int fails  = 0;
  int nfall = 0, nlatch = 0, nlow = 0;
  logic prev_clk = 1'b1;

  always #2 clk = ~clk;

  pad_pair_reader #(.HALF_CYCLES(H), .ADDR_W(16), .BASE_ADDR(BASE)) u_pad_pair_reader (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .pad_latch(pad_latch), .pad_clk(pad_clk), .pad_data(pad_data)
  );

  // pad models: load while latched, shift on each falling pad clock edge
  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (pad_latch) sreg[i] <= press[i];
      else if (prev_clk && !pad_clk) sreg[i] <= {1'b1, sreg[i][7:1]};
    end
    prev_clk <= pad_clk;
    if (prev_clk && !pad_clk) nfall <= nfall + 1;
    if (pad_latch) nlatch <= nlatch + 1;
    if (!pad_clk) nlow <= nlow + 1;
  end
  assign pad_data = {~sreg[1][0], ~sreg[0][0]};

  function automatic logic exp_bit(logic [7:0] p, int k);
    return (k >= 8) ? 1'b1 : ~p[k];
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic rd_raw(logic [15:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a;
    bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd_pad(int p, string req);
    logic [7:0] v;
    logic       e;
    rd_raw(BASE + 16'(p), v);
    e = exp_bit(cur[p], idx[p]);
    chk(v == {7'b0, e}, req, v, {7'b0, e});
    idx[p]++;
  endtask

  task automatic strobe(logic [15:0] a);
    @(negedge clk);
    bus_addr = a;
    bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic capture(logic [7:0] p0, logic [7:0] p1);
    int f0, l0, w0;
    press[0] = p0;
    press[1] = p1;
    f0 = nfall; l0 = nlatch; w0 = nlow;
    strobe(BASE);
    repeat (SPAN) @(negedge clk);
    chk(nlatch - l0 == H, "R2 latch width", nlatch - l0, H);
    chk(nfall - f0 == 8, "R2 pulse count", nfall - f0, 8);
    chk(nlow - w0 == 8 * H, "R2 low time", nlow - w0, 8 * H);
    cur[0] = p0; cur[1] = p1;
    idx[0] = 0; idx[1] = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int seed;
    logic [7:0] v;
    int l0, f0;
    seed = $urandom(32'd2024);
    press[0] = '0; press[1] = '0;
    cur[0] = '0; cur[1] = '0;
    idx[0] = 8; idx[1] = 8;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk(pad_latch == 1'b0, "R1 latch", pad_latch, 0);
    chk(pad_clk == 1'b1, "R1 clk", pad_clk, 1);
    rd_raw(BASE, v);       chk(v == 8'h01, "R1 pad1", v, 1);
    rd_raw(BASE + 16'd1, v); chk(v == 8'h01, "R1 pad2", v, 1);

    // R5 / R4 directed single-button and polarity patterns
    capture(8'h01, 8'h80);
    for (int k = 0; k < 9; k++) rd_pad(0, "R5 only A");
    for (int k = 0; k < 9; k++) rd_pad(1, "R5 only Right");
    capture(8'hFF, 8'h00);
    for (int k = 0; k < 10; k++) rd_pad(0, "R4 all pressed");
    for (int k = 0; k < 10; k++) rd_pad(1, "R6 none pressed");

    // R3 idle: clock high and latch low between captures
    chk(pad_clk == 1'b1 && pad_latch == 1'b0, "R3 idle lines", {pad_latch, pad_clk}, 1);

    // random patterns with interleaved reads (R4 R5 R6 R10)
    for (int it = 0; it < 25; it++) begin
      int n;
      capture(8'($urandom), 8'($urandom));
      n = $urandom_range(0, 11);
      for (int k = 0; k < n; k++) begin
        if ($urandom_range(0, 1) == 0) rd_pad(0, "R10 random pad1");
        else                           rd_pad(1, "R10 random pad2");
      end
      rd_pad(0, "R6 random tail");
    end

    // R7: reads during a capture see the old byte; new byte starts at A
    capture(8'h5A, 8'hC3);
    press[0] = 8'hA5; press[1] = 8'h3C;
    strobe(BASE);
    rd_pad(0, "R7 old during capture");
    rd_pad(0, "R7 old during capture");
    rd_pad(1, "R7 old during capture");
    repeat (SPAN) @(negedge clk);
    cur[0] = 8'hA5; cur[1] = 8'h3C; idx[0] = 0; idx[1] = 0;
    rd_pad(0, "R7 new after capture");
    rd_pad(1, "R7 new after capture");

    // R8: second strobe while busy is ignored
    press[0] = 8'h0F; press[1] = 8'hF0;
    l0 = nlatch; f0 = nfall;
    strobe(BASE);
    repeat (5 * H) @(negedge clk);
    strobe(BASE);
    repeat (SPAN - 5 * H) @(negedge clk);
    chk(nfall - f0 == 8, "R8 pulse count", nfall - f0, 8);
    chk(nlatch - l0 == H, "R8 latch once", nlatch - l0, H);
    cur[0] = 8'h0F; cur[1] = 8'hF0; idx[0] = 0; idx[1] = 0;
    rd_pad(0, "R8 data");

    // R9: write to second address starts nothing, foreign read is inert
    press[0] = 8'hFF; press[1] = 8'hFF;
    l0 = nlatch;
    strobe(BASE + 16'd1);
    repeat (SPAN) @(negedge clk);
    chk(nlatch == l0, "R9 no latch", nlatch - l0, 0);
    rd_pad(0, "R9 no reload");
    rd_raw(16'h4015, v);
    chk(v == 8'h00, "R9 foreign read", v, 0);
    rd_pad(0, "R9 no advance");
    rd_pad(1, "R9 no advance");

    finish_run();
  end
endmodule